// File: doc/BRIEF.md
# Modulo Timer With Overflow Alarm

This block is a 16-bit up-counter used as a one-shot wake alarm. Software programs a start value and a terminal (modulo) value, picks a prescale ratio, and connects the counter to a slow fixed-rate tick. The counter advances once per prescaled tick. When it passes from the terminal value back to the start value, an overflow flag is set. If interrupts are enabled, that flag drives the interrupt line until software clears it.

All state sits behind a simple 32-bit register bus. The bus has a write strobe, a read strobe, a byte address and write data. Reads are combinational. The tick input is a one-cycle pulse that is synchronous to the block clock.

Top module: `tmr_alarm`

## Requirements
- R1: After reset the count, start value, control fields and flag are zero, the modulo register is 0xFFFF, and irq_o is low.
- R2: addr_i[3:2] selects the register: 0 control, 1 count, 2 start value, 3 modulo. rdata_o is zero while rd_en_i is low. The count, start value and modulo registers read back with bits 31:16 at zero.
- R3: Control fields: bits 2:0 prescale, bits 4:3 clock select, bit 6 interrupt enable, bit 7 overflow flag. All other control bits read as zero.
- R4: Clock select 2 counts tick_i pulses. Clock select 0, 1 or 3 holds the counter still.
- R5: With prescale p, the counter advances once for every 2^p counted tick pulses.
- R6: On an advance, the counter increments unless it equals the modulo register. In that case it reloads the start value.
- R7: The flag sets on the advance that reloads from modulo to the start value. A modulo of N-1 with a start value of 0 sets the flag after N advances.
- R8: Any write to the count register loads the start value, not the written data, and restarts the prescaler. The write takes priority over an advance in the same cycle.
- R9: A control write with bit 7 at 0 clears the flag. A write with bit 7 at 1 leaves the flag unchanged. A flag set in the same cycle as a clearing write wins.
- R10: irq_o is high exactly while both the flag and the interrupt enable are set.
- R11: The prescaler restarts from zero when a control write changes the clock select. A write that leaves the clock select the same does not restart it.
- R12: Writes to the start value and modulo registers take effect on the next advance, with no buffering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle fixed-rate tick pulse |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A wrong prescaler phase shows up at the count register as an off-by-one count, one tick after the expected advance. The bench sweeps every prescale setting and reads the count at the exact multiple of 2^p where it must change. A wrong reload or compare shows up as a missing flag or an unexpected count on the very tick after the modulo value. Sweeps over several modulo and start-value pairs catch this. Flag-priority faults are visible on the control register in the cycle after a clearing write collides with a reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_INIT  = 2'd2,
    REG_MOD   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    CS_OFF   = 2'd0,
    CS_RSV1  = 2'd1,
    CS_TICK  = 2'd2,
    CS_RSV3  = 2'd3
  } clk_sel_e;

  localparam int unsigned CS_W          = 2;
  localparam int unsigned CTRL_PS_LSB   = 0;
  localparam int unsigned CTRL_CS_LSB   = 3;
  localparam int unsigned CTRL_IE_BIT   = 6;
  localparam int unsigned CTRL_FLAG_BIT = 7;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            step_o
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q, term;
  logic             hit;

  // terminal = 2^ps - 1, built as a thermometer mask
  always_comb begin
    term = '0;
    for (int i = 0; i < DIV_W; i++) term[i] = (i < int'(ps_i));
  end

  assign hit    = (div_q >= term);
  assign step_o = run_i & tick_i & ~restart_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (restart_i)         div_q <= '0;
    else if (run_i && tick_i)   div_q <= hit ? '0 : div_q + 1'b1;
  end

  p_restart_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (div_q == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_mod;

  assign at_mod = (cnt_q == mod_i);
  assign wrap_o = step_i & ~load_i & at_mod;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= init_i;
    else if (step_i)  cnt_q <= at_mod ? init_i : cnt_q + 1'b1;
  end

  p_load_init_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(init_i)));
  p_wrap_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == $past(init_i)));
  p_hold_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl #(
  parameter int unsigned PS_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [PS_W-1:0]          ps_wr_i,
  input  logic [tmr_pkg::CS_W-1:0] cs_wr_i,
  input  logic                     ie_wr_i,
  input  logic                     flag_wr_i,
  input  logic                     wrap_i,
  output logic [PS_W-1:0]          ps_o,
  output logic [tmr_pkg::CS_W-1:0] cs_o,
  output logic                     ie_o,
  output logic                     flag_o,
  output logic                     cs_change_o,
  output logic                     irq_o
);
  logic [PS_W-1:0]          ps_q;
  logic [tmr_pkg::CS_W-1:0] cs_q;
  logic                     ie_q, flag_q;

  assign cs_change_o = wr_i & (cs_wr_i != cs_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q <= '0;
      cs_q <= '0;
      ie_q <= 1'b0;
    end else if (wr_i) begin
      ps_q <= ps_wr_i;
      cs_q <= cs_wr_i;
      ie_q <= ie_wr_i;
    end
  end

  // set beats a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  flag_q <= 1'b0;
    else if (wrap_i)              flag_q <= 1'b1;
    else if (wr_i && !flag_wr_i)  flag_q <= 1'b0;
  end

  assign ps_o   = ps_q;
  assign cs_o   = cs_q;
  assign ie_o   = ie_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_q;

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flag_q);
  p_flag_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(wrap_i));
  p_flag_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_i && !flag_wr_i)) |=> flag_q);
endmodule

// File: rtl/tmr_alarm.sv
module tmr_alarm #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PS_W   = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import tmr_pkg::*;

  localparam logic [CNT_W-1:0] MOD_RST = '1;

  reg_sel_e         sel;
  logic             wr_ctrl, wr_cnt, wr_init, wr_mod;
  logic [CNT_W-1:0] init_q, mod_q, cnt;
  logic [PS_W-1:0]  ps;
  logic [CS_W-1:0]  cs;
  logic             ie, flag, cs_change, run, step, wrap, restart;

  assign sel     = reg_sel_e'(addr_i[3:2]);
  assign wr_ctrl = wr_en_i && (sel == REG_CTRL);
  assign wr_cnt  = wr_en_i && (sel == REG_COUNT);
  assign wr_init = wr_en_i && (sel == REG_INIT);
  assign wr_mod  = wr_en_i && (sel == REG_MOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      mod_q  <= MOD_RST;
    end else begin
      if (wr_init) init_q <= wdata_i[CNT_W-1:0];
      if (wr_mod)  mod_q  <= wdata_i[CNT_W-1:0];
    end
  end

  tmr_ctrl #(.PS_W(PS_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_ctrl),
    .ps_wr_i    (wdata_i[CTRL_PS_LSB +: PS_W]),
    .cs_wr_i    (wdata_i[CTRL_CS_LSB +: CS_W]),
    .ie_wr_i    (wdata_i[CTRL_IE_BIT]),
    .flag_wr_i  (wdata_i[CTRL_FLAG_BIT]),
    .wrap_i     (wrap),
    .ps_o       (ps),
    .cs_o       (cs),
    .ie_o       (ie),
    .flag_o     (flag),
    .cs_change_o(cs_change),
    .irq_o      (irq_o)
  );

  assign run     = (cs == CS_TICK);
  assign restart = wr_cnt | cs_change;

  tmr_prescaler #(.PS_W(PS_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (run),
    .restart_i(restart),
    .ps_i     (ps),
    .step_o   (step)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step),
    .load_i(wr_cnt),
    .init_i(init_q),
    .mod_i (mod_q),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (sel)
        REG_CTRL: begin
          rdata_o[CTRL_PS_LSB +: PS_W] = ps;
          rdata_o[CTRL_CS_LSB +: CS_W] = cs;
          rdata_o[CTRL_IE_BIT]         = ie;
          rdata_o[CTRL_FLAG_BIT]       = flag;
        end
        REG_COUNT: rdata_o[CNT_W-1:0] = cnt;
        REG_INIT:  rdata_o[CNT_W-1:0] = init_q;
        REG_MOD:   rdata_o[CNT_W-1:0] = mod_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  p_stopped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs != CS_TICK && !wr_cnt) |=> (cnt == $past(cnt)));
  p_irq_needs_ie_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie && !wr_ctrl) |=> !irq_o);
endmodule

// File: tb/tmr_alarm_test.sv
module tmr_alarm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  localparam logic [3:0] A_CTRL = 4'h0, A_CNT = 4'h4, A_INIT = 4'h8, A_MOD = 4'hC;

  always #4 clk = ~clk;

  tmr_alarm uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .tick_i (tick),
    .wr_en_i(wr_en),
    .rd_en_i(rd_en),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  function automatic logic [31:0] cw(int ps, int cs, int ie, int fl);
    return 32'(ps & 7) | (32'(cs & 3) << 3) | (32'(ie & 1) << 6) | (32'(fl & 1) << 7);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic tick_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic restart_at(int init, int md);
    wr(A_CTRL, cw(0, 0, 0, 0));
    wr(A_INIT, 32'(init));
    wr(A_MOD, 32'(md));
    wr(A_CNT, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_INIT, v); chk("R1 init", v, 0);
    rd(A_MOD, v);  chk("R1 modulo", v, 32'h0000_FFFF);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 strobe gating and reserved upper bits
    @(negedge clk); rd_en = 1'b0; addr = A_MOD; #1 chk("R2 no strobe", rdata, 0);
    wr(A_INIT, 32'hABCD_1234);
    rd(A_INIT, v); chk("R2 init upper zero", v, 32'h0000_1234);
    wr(A_CNT, 32'h0000_0042);
    rd(A_CNT, v); chk("R8 count write loads init", v, 32'h0000_1234);

    // R3 control field layout
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R3 ctrl fields", v, 32'h0000_005F);
    wr(A_CTRL, 0);

    // R4 clock select
    restart_at(0, 16'hFFFF);
    ticks(5); rd(A_CNT, v); chk("R4 cs0 stopped", v, 0);
    wr(A_CTRL, cw(0, 1, 0, 0)); ticks(5); rd(A_CNT, v); chk("R4 cs1 stopped", v, 0);
    wr(A_CTRL, cw(0, 3, 0, 0)); ticks(5); rd(A_CNT, v); chk("R4 cs3 stopped", v, 0);
    wr(A_CTRL, cw(0, 2, 0, 0)); ticks(5); rd(A_CNT, v); chk("R4 cs2 counts", v, 5);

    // R5 prescale sweep
    for (int p = 0; p < 8; p++) begin
      restart_at(0, 16'hFFFF);
      wr(A_CTRL, cw(p, 2, 0, 0));
      ticks(4 * (1 << p) - 1);
      rd(A_CNT, v); chk($sformatf("R5 ps%0d before edge", p), v, 3);
      ticks(1);
      rd(A_CNT, v); chk($sformatf("R5 ps%0d at edge", p), v, 4);
    end

    // R6 R7 R10 modulo and start sweep
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 5; k++) begin
        int i0 = b * 3;
        int m  = i0 + k;
        restart_at(i0, m);
        wr(A_CTRL, cw(0, 2, 1, 0));
        ticks(m - i0);
        rd(A_CNT, v);  chk($sformatf("R6 i%0d m%0d at modulo", i0, m), v, 32'(m));
        rd(A_CTRL, v); chk("R7 flag not yet", {31'b0, v[7]}, 0);
        chk("R10 irq low", {31'b0, irq}, 0);
        ticks(1);
        rd(A_CNT, v);  chk($sformatf("R6 i%0d m%0d reload", i0, m), v, 32'(i0));
        rd(A_CTRL, v); chk("R7 flag after N", {31'b0, v[7]}, 1);
        chk("R10 irq high", {31'b0, irq}, 1);
      end
    end

    // R9 R10 flag write semantics
    wr(A_CTRL, cw(0, 2, 1, 1));
    rd(A_CTRL, v); chk("R9 write 1 keeps", {31'b0, v[7]}, 1);
    wr(A_CTRL, cw(0, 0, 0, 1));
    chk("R10 ie off", {31'b0, irq}, 0);
    rd(A_CTRL, v); chk("R9 flag kept", {31'b0, v[7]}, 1);
    wr(A_CTRL, cw(0, 0, 1, 1));
    chk("R10 ie on", {31'b0, irq}, 1);
    wr(A_CTRL, cw(0, 0, 1, 0));
    rd(A_CTRL, v); chk("R9 write 0 clears", {31'b0, v[7]}, 0);
    chk("R10 irq after clear", {31'b0, irq}, 0);

    restart_at(0, 2);
    wr(A_CTRL, cw(0, 2, 1, 0));
    ticks(2);
    tick_wr(A_CTRL, cw(0, 2, 1, 0));
    rd(A_CTRL, v); chk("R9 set wins", {31'b0, v[7]}, 1);
    rd(A_CNT, v);  chk("R6 reload with write", v, 0);

    // R8 write priority and divider restart
    restart_at(5, 16'hFFFF);
    wr(A_CTRL, cw(0, 2, 0, 0));
    ticks(3);
    tick_wr(A_CNT, 0);
    rd(A_CNT, v); chk("R8 write beats step", v, 5);
    wr(A_CTRL, cw(2, 2, 0, 0));
    ticks(3);
    wr(A_CNT, 0);
    ticks(3); rd(A_CNT, v); chk("R8 divider restarted", v, 5);
    ticks(1); rd(A_CNT, v); chk("R8 step after 4", v, 6);

    // R11 clock-select change restarts divider
    ticks(3);
    wr(A_CTRL, cw(2, 2, 0, 0));
    ticks(1); rd(A_CNT, v); chk("R11 same cs no restart", v, 7);
    ticks(3);
    wr(A_CTRL, cw(2, 0, 0, 0));
    wr(A_CTRL, cw(2, 2, 0, 0));
    ticks(3); rd(A_CNT, v); chk("R11 cs change restart", v, 7);
    ticks(1); rd(A_CNT, v); chk("R11 step after restart", v, 8);

    // R12 immediate modulo and start writes
    wr(A_CTRL, cw(0, 2, 0, 0));
    wr(A_MOD, 9);
    ticks(1); rd(A_CNT, v); chk("R12 count to new modulo", v, 9);
    ticks(1); rd(A_CNT, v); chk("R12 reload", v, 5);
    rd(A_CTRL, v); chk("R12 flag on new modulo", {31'b0, v[7]}, 1);
    wr(A_MOD, 5);
    wr(A_INIT, 1);
    ticks(1); rd(A_CNT, v); chk("R12 new start value", v, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule